// File: doc/BRIEF.md
# Packet-Filter VM Arithmetic Execute Unit

This block is the arithmetic and logic execute stage of a small packet-filter virtual machine. Each accepted instruction carries an 8-bit opcode byte, a 64-bit destination operand, a 64-bit register source operand and a 32-bit immediate. The opcode byte names the operation, chooses between the register source and the immediate, and picks 64-bit or 32-bit working width. The result and an illegal-operation flag are registered and appear one clock after the instruction, marked by a valid strobe.

Opcode byte layout: bits 7:4 are the operation (0 add, 1 subtract, 2 multiply, 3 unsigned divide, 4 or, 5 and, 6 shift left, 7 logical shift right, 8 negate, 9 unsigned remainder, A xor, B move, C arithmetic shift right, D byte swap, E and F reserved). Bit 3 is the source bit. Bits 2:0 are the class: 3'b111 is the 64-bit mode, 3'b100 the 32-bit mode, all other values are not arithmetic classes. Register file, fetch, memory and branches live elsewhere.

A two-state controller drives the valid strobe. States: ST_IDLE (no result this cycle) and ST_VALID (result and flag belong to the instruction of the previous cycle). Transitions: ST_IDLE to ST_VALID when in_valid is high; ST_VALID to ST_VALID when in_valid stays high; ST_VALID to ST_IDLE and ST_IDLE to ST_IDLE when in_valid is low.

Top module: `pfvm_alu`

## Requirements
- R1: While and right after reset, out_valid, result and illegal are all 0.
- R2: An instruction accepted with in_valid high at a rising edge gives out_valid high after the next edge, with its result and flag; a cycle with in_valid low gives out_valid low after the next edge. Back-to-back instructions give back-to-back results.
- R3: Opcode bit 3 equal to 0 selects src_reg as operand; equal to 1 selects the immediate, sign-extended from 32 to 64 bits.
- R4: Operations 0, 1, 2, 4, 5, A and B give wrapping sum, wrapping difference (dst minus operand), low product, or, and, xor, and the operand itself.
- R5: Shifts use only the low 6 operand bits in 64-bit mode and the low 5 in 32-bit mode; op 6 fills zeros from the right, op 7 fills zeros from the left, op C fills copies of the working-width sign bit.
- R6: Negate (op 8) returns the two's-complement negation of dst and ignores both source operands.
- R7: Divide (op 3) and remainder (op 9) are unsigned; a zero divisor (within the working width) gives result 0 with illegal set.
- R8: In 32-bit mode (class 3'b100) only the low 32 bits of each operand take part and result bits 63:32 are 0; in 64-bit mode (class 3'b111) all 64 bits take part.
- R9: Byte swap (op D) reverses the byte order of the low 16, 32 or 64 bits of dst, chosen by the immediate value 16, 32 or 64 whatever the source bit, with the bits above cleared; any other immediate gives result 0 with illegal set.
- R10: Reserved operations E and F, and any class other than 3'b111 and 3'b100, give result 0 with illegal set.
- R11: Every other case gives illegal 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present this cycle |
| opcode | input | 8 | Operation, source bit, class |
| dst_val | input | 64 | Destination operand |
| src_val | input | 64 | Register source operand |
| imm | input | 32 | Immediate field |
| out_valid | output | 1 | Result strobe |
| result | output | 64 | Registered result |
| illegal | output | 1 | Reserved op, bad class, bad swap width or zero divisor |

## Verification
The clocked properties assume that in_valid and the opcode are never unknown once reset is released, and that the operands are stable around each rising edge so that the past-cycle values they compare against are those the unit captured. The bench drives every input from the falling edge with fully defined values, holds in_valid low through reset, and steers the corner operands (zero divisors with nonzero upper halves, masked shift amounts, sign bits at the working-width boundary) through that same legal interface.

// File: rtl/pfvm_pkg.sv
package pfvm_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'h0,
        OP_SUB  = 4'h1,
        OP_MUL  = 4'h2,
        OP_DIV  = 4'h3,
        OP_OR   = 4'h4,
        OP_AND  = 4'h5,
        OP_SHL  = 4'h6,
        OP_SHR  = 4'h7,
        OP_NEG  = 4'h8,
        OP_REM  = 4'h9,
        OP_XOR  = 4'hA,
        OP_MOV  = 4'hB,
        OP_SAR  = 4'hC,
        OP_SWAP = 4'hD,
        OP_RSVE = 4'hE,
        OP_RSVF = 4'hF
    } alu_op_e;

    localparam logic [2:0] CLS_WIDE   = 3'b111;
    localparam logic [2:0] CLS_NARROW = 3'b100;

    typedef struct packed {
        alu_op_e    op;
        logic       use_imm;
        logic [2:0] cls;
    } opc_t;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_VALID = 1'b1
    } ctl_state_e;

endpackage

// File: rtl/pfvm_src_sel.sv
module pfvm_src_sel #(
    parameter int DATA_W = 64,
    parameter int IMM_W  = 32
) (
    input  logic              use_imm,
    input  logic [DATA_W-1:0] reg_src,
    input  logic [IMM_W-1:0]  imm,
    output logic [DATA_W-1:0] operand
);
    localparam int EXT_W = DATA_W - IMM_W;

    logic [DATA_W-1:0] imm_ext;

    assign imm_ext = {{EXT_W{imm[IMM_W-1]}}, imm};
    assign operand = use_imm ? imm_ext : reg_src;
endmodule

// File: rtl/pfvm_byteswap.sv
module pfvm_byteswap #(
    parameter int DATA_W = 64,
    parameter int IMM_W  = 32
) (
    input  logic [DATA_W-1:0] din,
    input  logic [IMM_W-1:0]  width_sel,
    output logic [DATA_W-1:0] dout,
    output logic              bad_width
);
    localparam int NB = DATA_W / 8;

    logic [15:0]       sw16;
    logic [31:0]       sw32;
    logic [DATA_W-1:0] swall;

    for (genvar b = 0; b < 2; b++) begin : g_sw16
        assign sw16[8*b +: 8] = din[8*(1-b) +: 8];
    end
    for (genvar b = 0; b < 4; b++) begin : g_sw32
        assign sw32[8*b +: 8] = din[8*(3-b) +: 8];
    end
    for (genvar b = 0; b < NB; b++) begin : g_swall
        assign swall[8*b +: 8] = din[8*(NB-1-b) +: 8];
    end

    always_comb begin
        bad_width = 1'b0;
        dout      = '0;
        if (width_sel == IMM_W'(16)) begin
            dout[15:0] = sw16;
        end else if (width_sel == IMM_W'(32)) begin
            dout[31:0] = sw32;
        end else if (width_sel == IMM_W'(DATA_W)) begin
            dout = swall;
        end else begin
            bad_width = 1'b1;
        end
    end
endmodule

// File: rtl/pfvm_alu_core.sv
module pfvm_alu_core
    import pfvm_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int IMM_W  = 32
) (
    input  alu_op_e           op,
    input  logic              wide,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [IMM_W-1:0]  imm,
    output logic [DATA_W-1:0] res,
    output logic              bad
);
    localparam int HALF_W = DATA_W / 2;
    localparam int SH_W   = $clog2(DATA_W);

    logic [DATA_W-1:0] a_z, b_z, a_s, sw_out, raw;
    logic [SH_W-1:0]   shamt;
    logic              sw_bad, raw_bad;

    assign a_z   = wide ? a : {{HALF_W{1'b0}}, a[HALF_W-1:0]};
    assign b_z   = wide ? b : {{HALF_W{1'b0}}, b[HALF_W-1:0]};
    assign a_s   = wide ? a : {{HALF_W{a[HALF_W-1]}}, a[HALF_W-1:0]};
    assign shamt = wide ? b[SH_W-1:0] : {1'b0, b[SH_W-2:0]};

    pfvm_byteswap #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_swap (
        .din      (a),
        .width_sel(imm),
        .dout     (sw_out),
        .bad_width(sw_bad)
    );

    always_comb begin
        raw     = '0;
        raw_bad = 1'b0;
        unique case (op)
            OP_ADD:  raw = a_z + b_z;
            OP_SUB:  raw = a_z - b_z;
            OP_MUL:  raw = a_z * b_z;
            OP_DIV:  if (b_z == '0) raw_bad = 1'b1; else raw = a_z / b_z;
            OP_OR:   raw = a_z | b_z;
            OP_AND:  raw = a_z & b_z;
            OP_SHL:  raw = a_z << shamt;
            OP_SHR:  raw = a_z >> shamt;
            OP_NEG:  raw = '0 - a_z;
            OP_REM:  if (b_z == '0) raw_bad = 1'b1; else raw = a_z % b_z;
            OP_XOR:  raw = a_z ^ b_z;
            OP_MOV:  raw = b_z;
            OP_SAR:  raw = $signed(a_s) >>> shamt;
            OP_SWAP: begin
                raw_bad = sw_bad;
                raw     = sw_out;
            end
            OP_RSVE, OP_RSVF: raw_bad = 1'b1;
            default: raw_bad = 1'b1;
        endcase
    end

    assign bad = raw_bad;
    assign res = wide ? raw : {{HALF_W{1'b0}}, raw[HALF_W-1:0]};
endmodule

// File: rtl/pfvm_alu.sv
module pfvm_alu
    import pfvm_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int IMM_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [7:0]        opcode,
    input  logic [DATA_W-1:0] dst_val,
    input  logic [DATA_W-1:0] src_val,
    input  logic [IMM_W-1:0]  imm,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              illegal
);
    localparam int HALF_W = DATA_W / 2;

    opc_t              dec;
    ctl_state_e        state, state_nx;
    logic              cls_ok, wide, core_bad;
    logic [DATA_W-1:0] operand, core_res, next_res;
    logic              next_bad;

    assign dec    = opc_t'(opcode);
    assign cls_ok = (dec.cls == CLS_WIDE) || (dec.cls == CLS_NARROW);
    assign wide   = (dec.cls == CLS_WIDE);

    pfvm_src_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_src (
        .use_imm(dec.use_imm),
        .reg_src(src_val),
        .imm    (imm),
        .operand(operand)
    );

    pfvm_alu_core #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_core (
        .op  (dec.op),
        .wide(wide),
        .a   (dst_val),
        .b   (operand),
        .imm (imm),
        .res (core_res),
        .bad (core_bad)
    );

    assign next_bad = !cls_ok || core_bad;
    assign next_res = next_bad ? '0 : core_res;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  state_nx = in_valid ? ST_VALID : ST_IDLE;
            ST_VALID: state_nx = in_valid ? ST_VALID : ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result  <= '0;
            illegal <= 1'b0;
        end else if (in_valid) begin
            result  <= next_res;
            illegal <= next_bad;
        end
    end

    assign out_valid = (state == ST_VALID);

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r2_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    a_r8_narrow_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode[2:0] == CLS_NARROW) |=> result[DATA_W-1:HALF_W] == '0);

    a_r10_reserved_op: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode[7:4] >= 4'hE) |=> (illegal && result == '0));

    a_r6_neg_ignores_src: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode[7:4] == 4'h8 && opcode[2:0] == CLS_WIDE)
        |=> (result == ~$past(dst_val) + 1'b1) && !illegal);

    a_r7_zero_divisor: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (opcode[7:4] == 4'h3 || opcode[7:4] == 4'h9) && !opcode[3]
         && opcode[2:0] == CLS_WIDE && src_val == '0) |=> (illegal && result == '0));

    a_r3_mov_imm: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode == {4'hB, 1'b1, CLS_WIDE})
        |=> result == {{(DATA_W-IMM_W){$past(imm[IMM_W-1])}}, $past(imm)});
endmodule

// File: tb/tb_pfvm_alu.sv
module tb_pfvm_alu;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  opcode = '0;
    logic [63:0] dst_val = '0;
    logic [63:0] src_val = '0;
    logic [31:0] imm = '0;
    logic        out_valid;
    logic [63:0] result;
    logic        illegal;

    int checks = 0;
    int errors = 0;
    logic mon_on = 1'b0;
    logic done = 1'b0;

    typedef struct {
        logic [63:0] res;
        logic        ill;
        string       tag;
    } exp_t;

    exp_t sb[$];

    always #2 clk = ~clk;

    pfvm_alu dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
        .dst_val(dst_val), .src_val(src_val), .imm(imm),
        .out_valid(out_valid), .result(result), .illegal(illegal)
    );

    localparam logic [2:0] W64 = 3'b111;
    localparam logic [2:0] W32 = 3'b100;

    function automatic logic [7:0] mk(input logic [3:0] op, input logic k, input logic [2:0] c);
        return {op, k, c};
    endfunction

    // reference from the requirement text
    function automatic logic [64:0] model(input logic [7:0] oc, input logic [63:0] d,
                                          input logic [63:0] s, input logic [31:0] im);
        logic [63:0] o, dz, oz, r;
        logic [5:0]  sh;
        logic        w, bad;
        bad = 1'b0;
        r   = '0;
        if (oc[2:0] != W64 && oc[2:0] != W32) return {1'b1, 64'd0};
        w  = (oc[2:0] == W64);
        o  = oc[3] ? {{32{im[31]}}, im} : s;
        dz = w ? d : {32'd0, d[31:0]};
        oz = w ? o : {32'd0, o[31:0]};
        sh = w ? o[5:0] : {1'b0, o[4:0]};
        case (oc[7:4])
            4'h0: r = dz + oz;
            4'h1: r = dz - oz;
            4'h2: r = dz * oz;
            4'h3: if (oz == 0) bad = 1'b1; else r = dz / oz;
            4'h4: r = dz | oz;
            4'h5: r = dz & oz;
            4'h6: r = dz << sh;
            4'h7: r = dz >> sh;
            4'h8: r = 64'd0 - dz;
            4'h9: if (oz == 0) bad = 1'b1; else r = dz % oz;
            4'hA: r = dz ^ oz;
            4'hB: r = oz;
            4'hC: r = w ? 64'($signed(d) >>> sh) : 64'($signed({{32{d[31]}}, d[31:0]}) >>> sh);
            4'hD: begin
                if (im == 16)      r = {48'd0, d[7:0], d[15:8]};
                else if (im == 32) r = {32'd0, d[7:0], d[15:8], d[23:16], d[31:24]};
                else if (im == 64) for (int i = 0; i < 8; i++) r[8*i +: 8] = d[8*(7-i) +: 8];
                else bad = 1'b1;
            end
            default: bad = 1'b1;
        endcase
        if (bad) r = '0;
        if (!w) r[63:32] = '0;
        return {bad, r};
    endfunction

    task automatic drive(input logic [7:0] oc, input logic [63:0] d, input logic [63:0] s,
                         input logic [31:0] im, input logic [63:0] er, input logic ei, input string tag);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1; opcode = oc; dst_val = d; src_val = s; imm = im;
        e.res = er; e.ill = ei; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic issue(input logic [7:0] oc, input logic [63:0] d, input logic [63:0] s,
                         input logic [31:0] im, input string tag);
        logic [64:0] m;
        m = model(oc, d, s, im);
        drive(oc, d, s, im, m[63:0], m[64], tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (mon_on && out_valid) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R2 unexpected out_valid", 64'd1, 64'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(result == e.res, e.tag, result, e.res);
                chk(illegal == e.ill, {e.tag, " illegal"}, 64'(illegal), 64'(e.ill));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(out_valid == 0 && result == 0 && illegal == 0, "R1 in reset",
            {result[62:0], out_valid}, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        mon_on = 1'b1;
        @(negedge clk);
        chk(out_valid == 0 && result == 0 && illegal == 0, "R1 after release",
            {result[62:0], out_valid}, 64'd0);

        // R4 arithmetic and logic
        drive(mk(4'h0, 0, W64), 64'hFFFF_FFFF_FFFF_FFFF, 64'd2, 0, 64'd1, 0, "R4 add wrap");
        issue(mk(4'h1, 0, W64), 64'd5, 64'd7, 0, "R4 sub");
        issue(mk(4'h2, 0, W64), 64'h1_0000_0003, 64'h2_0000_0005, 0, "R4 mul");
        issue(mk(4'h4, 0, W64), 64'hF0F0, 64'h0F01, 0, "R4 or");
        issue(mk(4'h5, 0, W64), 64'hFF00_FF00, 64'h0FF0_0FF0, 0, "R4 and");
        issue(mk(4'hA, 0, W64), 64'hAAAA, 64'h5555, 0, "R4 xor");
        issue(mk(4'hB, 0, W64), 64'd9, 64'h1234_5678_9ABC_DEF0, 0, "R4 mov reg");
        // R3 source select
        drive(mk(4'hB, 1, W64), 64'd9, 64'd3, 32'hFFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 0, "R3 mov imm sext");
        issue(mk(4'h0, 1, W64), 64'd100, 64'd999, 32'hFFFF_FFF6, "R3 add imm neg");
        // R5 shifts
        drive(mk(4'h6, 0, W64), 64'd3, 64'd65, 0, 64'd6, 0, "R5 shl mask64");
        issue(mk(4'h7, 0, W64), 64'h8000_0000_0000_0000, 64'd63, 0, "R5 shr zero fill");
        drive(mk(4'hC, 1, W64), 64'h8000_0000_0000_0000, 0, 32'd4, 64'hF800_0000_0000_0000, 0, "R5 sar sign fill");
        drive(mk(4'h6, 1, W32), 64'd1, 0, 32'd33, 64'd2, 0, "R5 shl mask32");
        drive(mk(4'hC, 1, W32), 64'h0000_0000_8000_0000, 0, 32'd4, 64'h0000_0000_F800_0000, 0, "R5 sar32 sign");
        // R6 negate
        issue(mk(4'h8, 0, W64), 64'd1, 64'hDEAD, 32'h55, "R6 neg");
        drive(mk(4'h8, 1, W32), 64'h1234_0000_0000_0005, 64'd7, 32'h77, 64'h0000_0000_FFFF_FFFB, 0, "R6 neg32");
        // R7 divide and remainder
        issue(mk(4'h3, 0, W64), 64'hFFFF_FFFF_FFFF_FFF0, 64'd16, 0, "R7 div unsigned");
        issue(mk(4'h9, 1, W64), 64'd100, 0, 32'd7, "R7 rem");
        drive(mk(4'h3, 0, W64), 64'd100, 64'd0, 0, 64'd0, 1, "R7 div zero");
        drive(mk(4'h9, 1, W64), 64'd100, 64'd5, 32'd0, 64'd0, 1, "R7 rem zero imm");
        drive(mk(4'h3, 0, W32), 64'd100, 64'h5_0000_0000, 0, 64'd0, 1, "R7 div32 zero low half");
        // R8 narrow mode
        drive(mk(4'h0, 0, W32), 64'hAAAA_AAAA_FFFF_FFFF, 64'h1, 0, 64'd0, 0, "R8 add32 wrap");
        issue(mk(4'h2, 0, W32), 64'h7_0001_0001, 64'h9_0001_0001, 0, "R8 mul32");
        // R9 byte swap
        drive(mk(4'hD, 0, W64), 64'h0123_4567_89AB_CDEF, 0, 32'd16, 64'h0000_0000_0000_EFCD, 0, "R9 swap16");
        drive(mk(4'hD, 1, W64), 64'h0123_4567_89AB_CDEF, 0, 32'd32, 64'h0000_0000_EFCD_AB89, 0, "R9 swap32");
        drive(mk(4'hD, 0, W64), 64'h0123_4567_89AB_CDEF, 0, 32'd64, 64'hEFCD_AB89_6745_2301, 0, "R9 swap64");
        drive(mk(4'hD, 0, W64), 64'h0123_4567_89AB_CDEF, 0, 32'd8, 64'd0, 1, "R9 bad width");
        // R10 reserved op and bad class
        drive(mk(4'hE, 0, W64), 64'd1, 64'd1, 0, 64'd0, 1, "R10 op E");
        drive(mk(4'hF, 1, W32), 64'd1, 64'd1, 1, 64'd0, 1, "R10 op F");
        drive(mk(4'h0, 0, 3'b000), 64'd1, 64'd1, 0, 64'd0, 1, "R10 bad class");
        // R11 legal after illegal, back-to-back
        drive(mk(4'h0, 0, W64), 64'd40, 64'd2, 0, 64'd42, 0, "R11 legal clears flag");
        idle(1);
        idle(1);
        chk(out_valid == 0, "R2 out_valid low after idle", 64'(out_valid), 64'd0);
        // R2 isolated instruction then gap
        drive(mk(4'h7, 1, W64), 64'hF0, 0, 32'd4, 64'h0F, 0, "R2 single");
        idle(1);
        chk(out_valid == 1, "R2 strobe one cycle later", 64'(out_valid), 64'd1);
        idle(1);
        chk(out_valid == 0, "R2 strobe drops", 64'(out_valid), 64'd0);
        idle(2);
        chk(sb.size() == 0, "R2 all results seen", 64'(sb.size()), 64'd0);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule